// File: doc/BRIEF.md
# Thermal Shutdown Fault Supervisor

This block supervises over-temperature events in a power-management device. Its inputs are digitized hot flags from comparators: one for the main die, and one for each of four regulated rails. A rail's flag is qualified by that rail's enable bit. The operating mode and the ADC-enable bit decide whether the die flag takes part. When a qualified flag rises, the supervisor shuts the device down in order. In the first cycle it stops charging and drops the rails. One cycle later it opens the power switches that the mode calls for. It then waits a fixed deglitch interval and restarts only if the die has cooled. On the way back to normal operation it can request a power-up sequence.

A repeat counter watches for fault storms. When lockout is armed, it counts faults inside a two-second window. Once the count reaches a programmable threshold, the device stays dark until VIN is removed and reapplied. The block also reports a live status bit, a sticky flag with a read-clear strobe, and a maskable interrupt pulse. A ship mode keeps only the first LDO alive, and that LDO is gated by its own hot flag alone.

Top module: `tshut_supervisor`

## Requirements
- R1: Rail hot flags use the bit order [0] buck, [1] buck-boost, [2] LDO1, [3] LDO2. A rail flag causes a fault only when the matching `rail_en_req` bit is 1. In adapter mode (`mode_adapter`=1) the die flag always causes a fault.
- R2: In adapter mode, a fault clears `chg_en` and all `rail_en` bits in the first output cycle, while `in_sw_en` and `bat_sw_en` stay 1. Both switches go to 0 in the next cycle.
- R3: In battery-only mode with `adc_en`=0, `die_hot` causes no fault. A fault from a rail drops the rails and keeps `bat_sw_en` at 1 for the whole recovery.
- R4: In battery-only mode with `adc_en`=1, `die_hot` causes a fault. `bat_sw_en` goes to 0 one cycle after the rails drop.
- R5: Recovery waits DEGLITCH_MS worth of cycles. At the end of that wait the die flag must be low, except for the battery/ADC-off case of R3. If the die flag is still high, another full interval is waited. On recovery, the rails, switches and charging return to their normal values.
- R6: `tshut_stat` is 1 from the first fault cycle until recovery, and 0 otherwise. `tshut_flag` is set on a fault and stays set until a `flag_clr` strobe arrives. A set in the same cycle wins over the clear.
- R7: `irq` is a single-cycle pulse in the first fault cycle, issued only if `int_mask` was 0.
- R8: With `lockout_en`=1, the fault that brings the count within one window up to the threshold enters lockout. In lockout, charging, both switches and all rails are 0. The threshold is `lockout_thresh` clamped to the range 7..13. The window opens at the first fault and lasts WINDOW_MS.
- R9: Lockout ends only after `vin_present` has been 0 and then returns to 1. A deglitch interval with the die check then follows.
- R10: `seq_req` pulses for one cycle on the return to normal operation, and only if `seq_en` and `sys_ok` are both 1.
- R11: While `ship_ldo1_ao` is 1 in normal operation, the block enters ship mode. In ship mode, charging, both switches and rails 0, 1 and 3 are 0. Rail 2 equals `rail_en_req[2]` AND NOT `rail_hot[2]`. No fault, status, flag or interrupt is produced there.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_adapter | input | 1 | 1 = adapter mode, 0 = battery-only mode |
| adc_en | input | 1 | ADC enabled (brings in the die flag in battery mode) |
| lockout_en | input | 1 | Arms repeat-fault lockout |
| lockout_thresh | input | 4 | Lockout fault count, clamped to 7..13 |
| int_mask | input | 1 | Suppresses the interrupt pulse |
| vin_present | input | 1 | Input supply present |
| die_hot | input | 1 | Main die over-temperature flag |
| rail_hot | input | 4 | Rail over-temperature flags |
| rail_en_req | input | 4 | Configured rail enables |
| seq_en | input | 1 | Power sequencing in use |
| sys_ok | input | 1 | System voltage above the sequencing threshold |
| ship_ldo1_ao | input | 1 | Ship mode with LDO1 always on |
| flag_clr | input | 1 | Read-clear strobe for the sticky flag |
| chg_en | output | 1 | Charge enable |
| in_sw_en | output | 1 | Input switch enable |
| bat_sw_en | output | 1 | Battery switch enable |
| rail_en | output | 4 | Rail enables |
| seq_req | output | 1 | Power-up sequence request pulse |
| tshut_stat | output | 1 | Live fault status |
| tshut_flag | output | 1 | Sticky fault flag |
| irq | output | 1 | Interrupt pulse |

## Verification
Some orderings are checked on every cycle by assertions. A switch never opens in a fault state while rails or charging were still on in the cycle before. In lockout everything is dark. The interrupt and the sequence request are single pulses. The flag falls only after a clear strobe. In the battery/ADC-off recovery the battery switch stays closed. Other behaviour can only be shown by the bench scenarios. These include which flags count in each mode, the extra interval while the die stays hot, the threshold clamp, and the VIN toggle that releases lockout. The bench also checks the ship-mode gating of LDO1, and it compares every output against a behavioural model on every clock.

// File: rtl/tshut_pkg.sv
package tshut_pkg;
  localparam int NUM_RAILS = 4;
  localparam int RAIL_LDO1 = 2;
  localparam int THR_MIN   = 7;
  localparam int THR_MAX   = 13;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_CUT  = 3'd1,
    ST_WAIT = 3'd2,
    ST_LOCK = 3'd3,
    ST_SHIP = 3'd4
  } tshut_state_e;

  typedef enum logic [1:0] {
    K_ADAPTER   = 2'd0,
    K_BAT_ADC   = 2'd1,
    K_BAT_NOADC = 2'd2,
    K_LOCK      = 2'd3
  } tshut_kind_e;
endpackage

// File: rtl/tshut_fault_gate.sv
module tshut_fault_gate #(
  parameter int NR = 4
) (
  input  logic          mode_adapter,
  input  logic          adc_en,
  input  logic          die_hot,
  input  logic [NR-1:0] rail_hot,
  input  logic [NR-1:0] rail_en_req,
  output logic          fault_now
);
  logic [NR-1:0] rail_fault;
  logic          die_counts;

  genvar g;
  generate
    for (g = 0; g < NR; g++) begin : g_rail
      assign rail_fault[g] = rail_hot[g] & rail_en_req[g];
    end
  endgenerate

  assign die_counts = mode_adapter | adc_en;
  assign fault_now  = (|rail_fault) | (die_hot & die_counts);
endmodule

// File: rtl/tshut_repeat_guard.sv
module tshut_repeat_guard #(
  parameter int WIN_CYC = 400,
  parameter int THR_LO  = 7,
  parameter int THR_HI  = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       trigger,
  input  logic       lockout_en,
  input  logic [3:0] thresh,
  output logic       lock_hit
);
  localparam int WW = $clog2(WIN_CYC + 1);

  logic [WW-1:0] win_cnt;
  logic          win_act;
  logic [4:0]    hits;
  logic [4:0]    hits_new;
  logic [4:0]    thr_c;
  logic          expired;

  always_comb begin
    if (thresh < 4'(THR_LO))      thr_c = 5'(THR_LO);
    else if (thresh > 4'(THR_HI)) thr_c = 5'(THR_HI);
    else                          thr_c = {1'b0, thresh};
  end

  assign expired  = win_act && (win_cnt == WW'(WIN_CYC - 1));
  assign hits_new = ((win_act && !expired) ? hits : 5'd0) + 5'd1;
  assign lock_hit = trigger && lockout_en && (hits_new >= thr_c);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      win_act <= 1'b0;
      win_cnt <= '0;
      hits    <= '0;
    end else if (trigger) begin
      hits <= (hits_new > 5'd30) ? 5'd30 : hits_new;
      if (!win_act || expired) begin
        win_act <= 1'b1;
        win_cnt <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end else if (expired) begin
      win_act <= 1'b0;
      win_cnt <= '0;
      hits    <= '0;
    end else if (win_act) begin
      win_cnt <= win_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tshut_hold_timer.sv
module tshut_hold_timer #(
  parameter int HOLD_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] cnt;

  assign done = run && (cnt == HW'(HOLD_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tshut_supervisor.sv
module tshut_supervisor
  import tshut_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int WINDOW_MS   = 2000,
  parameter int DEGLITCH_MS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_adapter,
  input  logic                 adc_en,
  input  logic                 lockout_en,
  input  logic [3:0]           lockout_thresh,
  input  logic                 int_mask,
  input  logic                 vin_present,
  input  logic                 die_hot,
  input  logic [NUM_RAILS-1:0] rail_hot,
  input  logic [NUM_RAILS-1:0] rail_en_req,
  input  logic                 seq_en,
  input  logic                 sys_ok,
  input  logic                 ship_ldo1_ao,
  input  logic                 flag_clr,
  output logic                 chg_en,
  output logic                 in_sw_en,
  output logic                 bat_sw_en,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 seq_req,
  output logic                 tshut_stat,
  output logic                 tshut_flag,
  output logic                 irq
);
  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int WIN_CYC    = CYC_PER_MS * WINDOW_MS;
  localparam int DGL_CYC    = CYC_PER_MS * DEGLITCH_MS;

  tshut_state_e st_q, st_n;
  tshut_kind_e  kind_q, kind_n;
  logic lock_q, lock_n, seen_q, seen_n;
  logic fault_now, lock_hit, dgl_done, trig, leave, need_die;

  logic                 chg_n, in_n, bat_n, seq_n, stat_n, flag_n, irq_n;
  logic [NUM_RAILS-1:0] rail_n, ldo1_only;

  tshut_fault_gate #(.NR(NUM_RAILS)) u_gate (
    .mode_adapter(mode_adapter),
    .adc_en      (adc_en),
    .die_hot     (die_hot),
    .rail_hot    (rail_hot),
    .rail_en_req (rail_en_req),
    .fault_now   (fault_now)
  );

  tshut_repeat_guard #(.WIN_CYC(WIN_CYC), .THR_LO(THR_MIN), .THR_HI(THR_MAX)) u_guard (
    .clk       (clk),
    .rst       (rst),
    .clear     (st_q == ST_LOCK),
    .trigger   (trig),
    .lockout_en(lockout_en),
    .thresh    (lockout_thresh),
    .lock_hit  (lock_hit)
  );

  tshut_hold_timer #(.HOLD_CYC(DGL_CYC)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (st_q == ST_WAIT),
    .done(dgl_done)
  );

  assign need_die = (kind_q != K_BAT_NOADC);

  always_comb begin
    ldo1_only = '0;
    ldo1_only[RAIL_LDO1] = rail_en_req[RAIL_LDO1] & ~rail_hot[RAIL_LDO1];
  end

  // state transitions
  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    lock_n = lock_q;
    seen_n = seen_q;
    trig   = 1'b0;
    leave  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (ship_ldo1_ao) begin
          st_n = ST_SHIP;
        end else if (fault_now) begin
          trig   = 1'b1;
          st_n   = ST_CUT;
          lock_n = lock_hit;
          kind_n = mode_adapter ? K_ADAPTER : (adc_en ? K_BAT_ADC : K_BAT_NOADC);
        end
      end
      ST_CUT: begin
        seen_n = 1'b0;
        if (lock_q) begin
          st_n   = ST_LOCK;
          kind_n = K_LOCK;
        end else begin
          st_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (dgl_done && !(need_die && die_hot)) begin
          st_n   = ST_RUN;
          leave  = 1'b1;
          lock_n = 1'b0;
        end
      end
      ST_LOCK: begin
        if (!vin_present) begin
          seen_n = 1'b1;
        end else if (seen_q) begin
          seen_n = 1'b0;
          st_n   = ST_WAIT;
        end
      end
      ST_SHIP: begin
        if (!ship_ldo1_ao) st_n = ST_RUN;
      end
      default: st_n = ST_RUN;
    endcase
  end

  // output decode from the next state
  always_comb begin
    chg_n  = 1'b0;
    in_n   = 1'b0;
    bat_n  = 1'b0;
    rail_n = '0;
    stat_n = 1'b1;
    unique case (st_n)
      ST_RUN: begin
        chg_n  = mode_adapter;
        in_n   = mode_adapter;
        bat_n  = 1'b1;
        rail_n = rail_en_req;
        stat_n = 1'b0;
      end
      ST_CUT: begin
        in_n  = (kind_n == K_ADAPTER);
        bat_n = 1'b1;
      end
      ST_WAIT: bat_n = (kind_n == K_BAT_NOADC);
      ST_LOCK: bat_n = 1'b0;
      ST_SHIP: begin
        rail_n = ldo1_only;
        stat_n = tshut_stat;
      end
      default: stat_n = 1'b0;
    endcase
    flag_n = trig ? 1'b1 : (flag_clr ? 1'b0 : tshut_flag);
    irq_n  = trig & ~int_mask;
    seq_n  = leave & seq_en & sys_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_RUN;
      kind_q     <= K_ADAPTER;
      lock_q     <= 1'b0;
      seen_q     <= 1'b0;
      chg_en     <= 1'b0;
      in_sw_en   <= 1'b0;
      bat_sw_en  <= 1'b0;
      rail_en    <= '0;
      seq_req    <= 1'b0;
      tshut_stat <= 1'b0;
      tshut_flag <= 1'b0;
      irq        <= 1'b0;
    end else begin
      st_q       <= st_n;
      kind_q     <= kind_n;
      lock_q     <= lock_n;
      seen_q     <= seen_n;
      chg_en     <= chg_n;
      in_sw_en   <= in_n;
      bat_sw_en  <= bat_n;
      rail_en    <= rail_n;
      seq_req    <= seq_n;
      tshut_stat <= stat_n;
      tshut_flag <= flag_n;
      irq        <= irq_n;
    end
  end
endmodule

// File: rtl/tshut_supervisor_chk.sv
module tshut_supervisor_chk
  import tshut_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] st,
  input logic [1:0] kind,
  input logic       int_mask,
  input logic       flag_clr,
  input logic       chg_en,
  input logic       in_sw_en,
  input logic       bat_sw_en,
  input logic [3:0] rail_en,
  input logic       seq_req,
  input logic       tshut_stat,
  input logic       tshut_flag,
  input logic       irq
);
  logic in_fault;
  assign in_fault = (st == ST_WAIT) || (st == ST_LOCK);

  assert_rails_before_input_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(in_sw_en) && in_fault) |-> ($past(rail_en) == 4'b0 && !$past(chg_en)));

  assert_rails_before_battery_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(bat_sw_en) && in_fault) |-> ($past(rail_en) == 4'b0 && !$past(chg_en)));

  assert_noadc_keeps_battery_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && kind == K_BAT_NOADC) |-> bat_sw_en);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(tshut_flag) |-> $past(flag_clr));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!$past(int_mask) && tshut_flag && tshut_stat));

  assert_lockout_dark_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOCK) |-> (!chg_en && !in_sw_en && !bat_sw_en && rail_en == 4'b0));

  assert_seq_single_R10: assert property (@(posedge clk) disable iff (rst)
    seq_req |=> !seq_req);

  assert_ship_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SHIP) |-> (!irq && !tshut_stat && !in_sw_en && !bat_sw_en));
endmodule

bind tshut_supervisor tshut_supervisor_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .st        (st_q),
  .kind      (kind_q),
  .int_mask  (int_mask),
  .flag_clr  (flag_clr),
  .chg_en    (chg_en),
  .in_sw_en  (in_sw_en),
  .bat_sw_en (bat_sw_en),
  .rail_en   (rail_en),
  .seq_req   (seq_req),
  .tshut_stat(tshut_stat),
  .tshut_flag(tshut_flag),
  .irq       (irq)
);

// File: tb/tshut_supervisor_test.sv
`timescale 1ns/1ps
module tshut_supervisor_test;
  localparam int CLK_HZ = 10_000;
  localparam int WIN_MS = 40;
  localparam int DGL_MS = 2;
  localparam int WIN    = CLK_HZ / 1000 * WIN_MS;
  localparam int DGL    = CLK_HZ / 1000 * DGL_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_adapter = 1'b1, adc_en = 1'b0, lockout_en = 1'b0, int_mask = 1'b0;
  logic [3:0] lockout_thresh = 4'd7;
  logic vin_present = 1'b1, die_hot = 1'b0, seq_en = 1'b0, sys_ok = 1'b0;
  logic ship_ldo1_ao = 1'b0, flag_clr = 1'b0;
  logic [3:0] rail_hot = 4'h0, rail_en_req = 4'hF;
  logic chg_en, in_sw_en, bat_sw_en, seq_req, tshut_stat, tshut_flag, irq;
  logic [3:0] rail_en;

  int tests = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  tshut_supervisor #(.CLK_HZ(CLK_HZ), .WINDOW_MS(WIN_MS), .DEGLITCH_MS(DGL_MS)) uut (
    .clk(clk), .rst(rst), .mode_adapter(mode_adapter), .adc_en(adc_en),
    .lockout_en(lockout_en), .lockout_thresh(lockout_thresh), .int_mask(int_mask),
    .vin_present(vin_present), .die_hot(die_hot), .rail_hot(rail_hot),
    .rail_en_req(rail_en_req), .seq_en(seq_en), .sys_ok(sys_ok),
    .ship_ldo1_ao(ship_ldo1_ao), .flag_clr(flag_clr), .chg_en(chg_en),
    .in_sw_en(in_sw_en), .bat_sw_en(bat_sw_en), .rail_en(rail_en),
    .seq_req(seq_req), .tshut_stat(tshut_stat), .tshut_flag(tshut_flag), .irq(irq)
  );

  // behavioural reference: phase names as strings, counters as integers
  string ph = "normal";
  string why = "adapter";
  bit want_lock = 0, saw_low = 0;
  int dg = 0, win_left = 0, hot_count = 0;
  bit e_chg, e_in, e_bat, e_seq, e_stat, e_flag, e_irq;
  bit [3:0] e_rail;

  always @(posedge clk) begin
    bit fault, fire, back;
    int lim;
    string nxt;
    if (rst) begin
      ph = "normal"; why = "adapter"; want_lock = 0; saw_low = 0; dg = 0;
      win_left = 0; hot_count = 0;
      {e_chg, e_in, e_bat, e_seq, e_stat, e_flag, e_irq} = '0; e_rail = 0;
    end else begin
      fault = ((rail_hot & rail_en_req) != 0) || (die_hot && (mode_adapter || adc_en));
      fire = 0; back = 0; nxt = ph;
      lim = lockout_thresh < 7 ? 7 : (lockout_thresh > 13 ? 13 : int'(lockout_thresh));
      if (ph == "normal") begin
        if (ship_ldo1_ao) nxt = "ship";
        else if (fault) begin
          fire = 1; nxt = "cut";
          why = mode_adapter ? "adapter" : (adc_en ? "batadc" : "batplain");
        end
      end else if (ph == "cut") begin
        saw_low = 0;
        if (want_lock) begin nxt = "lock"; why = "lock"; end else nxt = "wait";
      end else if (ph == "wait") begin
        if (dg + 1 >= DGL) begin
          dg = 0;
          if (why == "batplain" || !die_hot) begin nxt = "normal"; back = 1; want_lock = 0; end
        end else dg++;
      end else if (ph == "lock") begin
        if (!vin_present) saw_low = 1;
        else if (saw_low) begin saw_low = 0; nxt = "wait"; end
      end else if (ph == "ship") begin
        if (!ship_ldo1_ao) nxt = "normal";
      end
      // repeat window
      if (ph == "lock") begin
        win_left = 0; hot_count = 0;
      end else if (fire) begin
        if (win_left == 0) begin win_left = WIN; hot_count = 0; end
        hot_count++;
        win_left--;
        want_lock = lockout_en && hot_count >= lim;
      end else if (win_left > 0) begin
        win_left--;
        if (win_left == 0) hot_count = 0;
      end
      if (nxt != "wait") dg = 0;
      ph = nxt;
      e_flag = fire ? 1 : (flag_clr ? 0 : e_flag);
      e_irq = fire && !int_mask;
      e_seq = back && seq_en && sys_ok;
      if (ph == "normal") begin
        e_chg = mode_adapter; e_in = mode_adapter; e_bat = 1; e_rail = rail_en_req; e_stat = 0;
      end else if (ph == "ship") begin
        e_chg = 0; e_in = 0; e_bat = 0;
        e_rail = {1'b0, rail_en_req[2] & ~rail_hot[2], 2'b00};
      end else begin
        e_chg = 0; e_rail = 0; e_stat = 1;
        e_in = (ph == "cut") && (why == "adapter");
        e_bat = (ph == "cut") || (ph == "wait" && why == "batplain");
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    chk(rail_en == e_rail, "R1", "rail_en", rail_en, e_rail);
    chk(chg_en == e_chg, "R2", "chg_en", chg_en, e_chg);
    chk(in_sw_en == e_in, "R2", "in_sw_en", in_sw_en, e_in);
    chk(bat_sw_en == e_bat, "R4", "bat_sw_en", bat_sw_en, e_bat);
    chk(tshut_stat == e_stat, "R6", "tshut_stat", tshut_stat, e_stat);
    chk(tshut_flag == e_flag, "R6", "tshut_flag", tshut_flag, e_flag);
    chk(irq == e_irq, "R7", "irq", irq, e_irq);
    chk(seq_req == e_seq, "R10", "seq_req", seq_req, e_seq);
    if (cyc > 150000) begin
      chk(0, "WATCHDOG", "cycles", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_normal(input string req);
    int k = 0;
    while (tshut_stat && k < 4 * DGL) begin tick(); k++; end
    chk(!tshut_stat, req, "recovered", tshut_stat, 0);
  endtask

  initial begin
    tick(3);
    chk({chg_en, in_sw_en, bat_sw_en, rail_en, tshut_flag, irq} == 0, "R12", "reset outputs", rail_en, 0);
    rst = 1'b0;
    tick();
    chg(1);

    // R1: disabled rail is ignored
    rail_en_req = 4'b1110; rail_hot = 4'b0001; tick(3);
    chk(!tshut_stat && rail_en == 4'b1110, "R1", "masked rail flag", tshut_stat, 0);
    rail_hot = 4'b0;

    // R2 / R5 / R10: adapter die fault with slow cool-down
    seq_en = 1; sys_ok = 1; die_hot = 1; tick();
    chk(rail_en == 0 && !chg_en && in_sw_en && bat_sw_en, "R2", "first cut cycle", in_sw_en, 1);
    chk(irq, "R7", "irq pulse", irq, 1);
    tick();
    chk(!in_sw_en && !bat_sw_en && !irq, "R2", "switches open", in_sw_en, 0);
    tick(DGL + 3);
    chk(tshut_stat, "R5", "hot die holds fault", tshut_stat, 1);
    die_hot = 0;
    begin
      int k = 0;
      bit seen = 0;
      while (!seen && k < 3 * DGL) begin tick(); k++; if (seq_req) seen = 1; end
      chk(seen, "R10", "sequence request", seen, 1);
    end
    chk(rail_en == 4'b1110 && in_sw_en, "R5", "rails back", rail_en, 4'b1110);

    // R6: sticky flag and clear
    chk(tshut_flag, "R6", "flag held", tshut_flag, 1);
    flag_clr = 1; tick(); flag_clr = 0;
    chk(!tshut_flag, "R6", "flag cleared", tshut_flag, 0);

    // R3: battery mode, ADC off
    mode_adapter = 0; adc_en = 0; rail_en_req = 4'hF; die_hot = 1; tick(3);
    chk(!tshut_stat, "R3", "die ignored", tshut_stat, 0);
    rail_hot = 4'b1000; tick(); rail_hot = 0;
    chk(tshut_stat && rail_en == 0, "R3", "rail fault", tshut_stat, 1);
    tick(2);
    chk(bat_sw_en, "R3", "battery kept", bat_sw_en, 1);
    wait_normal("R5");
    die_hot = 0; tick();

    // R4: battery mode, ADC on
    adc_en = 1; die_hot = 1; tick(); die_hot = 0;
    chk(tshut_stat && bat_sw_en, "R4", "die counted", tshut_stat, 1);
    tick();
    chk(!bat_sw_en, "R4", "battery opened", bat_sw_en, 0);
    wait_normal("R4");

    // R7: masked interrupt
    int_mask = 1; rail_hot = 4'b0010; tick(); rail_hot = 0;
    chk(!irq && tshut_flag, "R7", "masked irq", irq, 0);
    wait_normal("R7");
    int_mask = 0;

    // R8: lockout, threshold 3 clamps to 7
    mode_adapter = 1; adc_en = 0; tick(WIN + 20);
    lockout_en = 1; lockout_thresh = 4'd3;
    for (int n = 0; n < 6; n++) begin
      rail_hot = 4'b0001; tick(); rail_hot = 0; tick(DGL + 4);
    end
    chk(in_sw_en && !tshut_stat, "R8", "six faults no lock", in_sw_en, 1);
    rail_hot = 4'b0001; tick(); rail_hot = 0;
    tick(3 * DGL);
    chk(tshut_stat && !in_sw_en && !bat_sw_en && rail_en == 0, "R8", "locked out", bat_sw_en, 0);

    // R9: VIN toggle releases lockout
    vin_present = 0; tick(2);
    chk(tshut_stat, "R9", "still locked with VIN low", tshut_stat, 1);
    vin_present = 1;
    wait_normal("R9");
    chk(in_sw_en && bat_sw_en, "R9", "switches after toggle", in_sw_en, 1);

    // R11: ship mode with LDO1 always on
    lockout_en = 0; flag_clr = 1; tick(); flag_clr = 0;
    ship_ldo1_ao = 1; tick(2);
    chk(rail_en == 4'b0100 && !in_sw_en && !bat_sw_en, "R11", "ship rails", rail_en, 4'b0100);
    rail_hot = 4'b0100; tick(2);
    chk(rail_en == 0 && !tshut_stat && !tshut_flag && !irq, "R11", "LDO1 hot", rail_en, 0);
    rail_hot = 0; tick(2);
    chk(rail_en == 4'b0100, "R11", "LDO1 back", rail_en, 4'b0100);
    ship_ldo1_ao = 0; tick(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chg(input bit exp);
    chk(chg_en == exp && bat_sw_en, "R12", "leave reset to normal", chg_en, exp);
  endtask
endmodule